// File: doc/BRIEF.md
# MSI Write-Back Snooping Cache Controller

This block is the coherence controller for one private, write-back, direct-mapped cache on a shared snooping bus. Each line keeps a tag and one of three coherence states: Modified, Shared or Invalid. The controller turns processor loads and stores into bus reads, read-for-ownership requests and writebacks. It also watches the transactions of the other caches and gives up or downgrades its own copies as needed. When it owns dirty data that another cache asks for, it supplies that data.

A line holds one data word. The low `IDX_W` address bits select the line and the remaining bits form the tag. The processor holds `cpu_req` and its operands until a one-cycle `cpu_ready` pulse. The controller owns the bus from `bus_gnt` until `bus_done`. Snooped transactions arrive as single-cycle `snp_valid` pulses and are answered on the next cycle.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. `cpu_ready`, `bus_req` and `snp_flush` are low.
- R2: A read of an Invalid or tag-mismatched line issues a bus read (command code 1) to its address. It returns `bus_rdata` and leaves the line Shared.
- R3: A write to an Invalid, tag-mismatched or Shared line issues read-for-ownership (code 2). The line becomes Modified and holds the written word.
- R4: A read hit in Shared or Modified, and a write hit in Modified, finish with `cpu_ready` one cycle after acceptance and with no bus request.
- R5: On a miss whose victim line is Modified, a writeback (code 3) carrying the victim address and data completes first. Only after it does the controller request the fill command.
- R6: A snooped bus read that hits a Modified line raises `snp_flush` for one cycle with the line data on `snp_data`, one cycle after `snp_valid`. The line becomes Shared.
- R7: A snooped read-for-ownership that hits a Modified line flushes the data in the same way and leaves the line Invalid.
- R8: A snooped read-for-ownership that hits a Shared line invalidates it without a flush. A snooped bus read that hits a Shared line, or any snoop whose tag differs from the stored tag, leaves the line unchanged and produces no flush.
- R9: A snoop that arrives while a request waits for grant is applied first. If it changed the pending line, the request is withdrawn and decided again, so a writeback of a line that the snoop invalidated is never issued.
- R10: `cpu_from_cache` reports the `bus_shared_in` value sampled when the last fill completed.
- R11: While granted, `bus_req`, `bus_cmd` and `bus_addr` stay steady until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (index = low IDX_W bits) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data (write data for writes) |
| cpu_from_cache | output | 1 | Last fill was supplied by another cache |
| bus_req | output | 1 | Bus request, held through the transaction |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_done | input | 1 | Transaction complete, fill data valid |
| bus_rdata | input | DATA_W | Fill data |
| bus_shared_in | input | 1 | Fill data came from a cache flush |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Flushed data |

## Verification
The bench walks a replacement sequence that evicts dirty lines into the same index. A design that skipped the writeback, or issued the fill before it, would lose the stored word, and the later reread from memory exposes this. Upgrades from Shared are separated from silent hits in Modified by counting bus requests, which catches a controller that treats Shared as writable. The sharpest case is a snoop that invalidates a dirty victim while its writeback waits for grant. A controller that does not re-decide would write back stale data after another cache has taken ownership.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_REQ  = 2'd1,
    CS_WAIT = 2'd2,
    CS_RESP = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/msi_cpu_xfer.sv
module msi_cpu_xfer
  import msi_pkg::*;
(
  input  line_st_e cur,
  input  logic     tag_eq,
  input  logic     is_wr,
  output logic     need_bus,
  output bus_cmd_e cmd,
  output line_st_e nxt
);
  logic present;
  assign present = tag_eq && (cur != LN_INV);

  always_comb begin
    need_bus = 1'b0;
    cmd      = BC_NONE;
    nxt      = cur;
    if (is_wr) begin
      nxt = LN_MOD;
      if (!(present && cur == LN_MOD)) begin
        need_bus = 1'b1;
        cmd      = BC_RDX;
      end
    end else if (!present) begin
      need_bus = 1'b1;
      cmd      = BC_RD;
      nxt      = LN_SHR;
    end
  end
endmodule

// File: rtl/msi_snoop_xfer.sv
module msi_snoop_xfer
  import msi_pkg::*;
(
  input  line_st_e cur,
  input  bus_cmd_e cmd,
  output line_st_e nxt,
  output logic     flush
);
  always_comb begin
    nxt   = cur;
    flush = 1'b0;
    case (cur)
      LN_MOD: begin
        if (cmd == BC_RD) begin
          nxt   = LN_SHR;
          flush = 1'b1;
        end else if (cmd == BC_RDX) begin
          nxt   = LN_INV;
          flush = 1'b1;
        end
      end
      LN_SHR: begin
        if (cmd == BC_RDX) nxt = LN_INV;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_e          w_state,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              w_data_en,
  input  logic [DATA_W-1:0] w_data,
  input  logic              s_en,
  input  logic [IDX_W-1:0]  s_idx,
  input  line_st_e          s_state
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else begin
      if (w_en) st_q[w_idx] <= w_state;
      if (s_en) st_q[s_idx] <= s_state;
    end
  end

  // Tag and data carry no reset so they map onto memory primitives.
  always_ff @(posedge clk) begin
    if (w_en) tag_q[w_idx] <= w_tag;
    if (w_en && w_data_en) data_q[w_idx] <= w_data;
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];

  AST_ONE_STATE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(w_en && s_en)); // R9
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          l_state,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output line_st_e          upd_state,
  output logic              flush_q,
  output logic [DATA_W-1:0] flush_data_q
);
  logic     hit;
  logic     need_flush;
  line_st_e nxt;

  assign hit = en && snp_valid && (l_tag == snp_tag) && (l_state != LN_INV);

  msi_snoop_xfer u_xfer (
    .cur   (l_state),
    .cmd   (snp_cmd),
    .nxt   (nxt),
    .flush (need_flush)
  );

  assign upd_en    = hit && (nxt != l_state);
  assign upd_idx   = snp_idx;
  assign upd_state = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q      <= 1'b0;
      flush_data_q <= '0;
    end else begin
      flush_q <= hit && need_flush;
      if (hit && need_flush) flush_data_q <= l_data;
    end
  end

  AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(snp_valid)); // R6
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (flush_q && !$past(snp_valid, 1)) |-> 1'b0); // R7
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_from_cache,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_e          a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  ctl_st_e  ctl_q;
  bus_cmd_e cmd_q;
  line_st_e pend_nxt_q;

  logic     need_bus;
  bus_cmd_e p_cmd;
  line_st_e p_nxt;
  logic     victim_dirty;

  logic              sn_en, sn_upd_en;
  logic [IDX_W-1:0]  sn_upd_idx;
  line_st_e          sn_upd_state;

  logic              hit_wr, fill, wb_done, accept_hit;
  logic              w_en, w_data_en;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;
  line_st_e          w_state;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  msi_cpu_xfer u_cpu_xfer (
    .cur      (a_state),
    .tag_eq   (a_tag == cpu_tag),
    .is_wr    (cpu_we),
    .need_bus (need_bus),
    .cmd      (p_cmd),
    .nxt      (p_nxt)
  );

  assign victim_dirty = (a_tag != cpu_tag) && (a_state == LN_MOD);

  // Snoops are ignored only while this cache owns the bus.
  assign sn_en = (ctl_q != CS_WAIT);

  msi_snoop_unit #(
    .IDX_W (IDX_W), .TAG_W (TAG_W), .DATA_W (DATA_W)
  ) u_snoop (
    .clk          (clk),
    .rst          (rst),
    .en           (sn_en),
    .snp_valid    (snp_valid),
    .snp_cmd      (bus_cmd_e'(snp_cmd)),
    .snp_idx      (snp_idx),
    .snp_tag      (snp_tag),
    .l_state      (b_state),
    .l_tag        (b_tag),
    .l_data       (b_data),
    .upd_en       (sn_upd_en),
    .upd_idx      (sn_upd_idx),
    .upd_state    (sn_upd_state),
    .flush_q      (snp_flush),
    .flush_data_q (snp_data)
  );

  assign accept_hit = (ctl_q == CS_IDLE) && cpu_req && !snp_valid && !need_bus;
  assign hit_wr     = accept_hit && cpu_we;
  assign fill       = (ctl_q == CS_WAIT) && bus_done && (cmd_q != BC_WB);
  assign wb_done    = (ctl_q == CS_WAIT) && bus_done && (cmd_q == BC_WB);

  assign w_en      = hit_wr || fill || wb_done;
  assign w_data_en = hit_wr || fill;
  assign w_tag     = wb_done ? a_tag : cpu_tag;
  assign w_state   = wb_done ? LN_INV : (fill ? pend_nxt_q : LN_MOD);
  assign w_data    = cpu_we ? cpu_wdata : bus_rdata;

  msi_line_store #(
    .IDX_W (IDX_W), .TAG_W (TAG_W), .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .a_idx     (cpu_idx),
    .a_state   (a_state),
    .a_tag     (a_tag),
    .a_data    (a_data),
    .b_idx     (snp_idx),
    .b_state   (b_state),
    .b_tag     (b_tag),
    .b_data    (b_data),
    .w_en      (w_en),
    .w_idx     (cpu_idx),
    .w_state   (w_state),
    .w_tag     (w_tag),
    .w_data_en (w_data_en),
    .w_data    (w_data),
    .s_en      (sn_upd_en),
    .s_idx     (sn_upd_idx),
    .s_state   (sn_upd_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q          <= CS_IDLE;
      cmd_q          <= BC_NONE;
      pend_nxt_q     <= LN_INV;
      bus_req        <= 1'b0;
      bus_addr       <= '0;
      bus_wdata      <= '0;
      cpu_ready      <= 1'b0;
      cpu_rdata      <= '0;
      cpu_from_cache <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      case (ctl_q)
        CS_IDLE: begin
          if (cpu_req && !snp_valid) begin
            if (!need_bus) begin
              cpu_ready <= 1'b1;
              cpu_rdata <= cpu_we ? cpu_wdata : a_data;
              ctl_q     <= CS_RESP;
            end else begin
              bus_req    <= 1'b1;
              ctl_q      <= CS_REQ;
              pend_nxt_q <= p_nxt;
              if (victim_dirty) begin
                cmd_q     <= BC_WB;
                bus_addr  <= {a_tag, cpu_idx};
                bus_wdata <= a_data;
              end else begin
                cmd_q     <= p_cmd;
                bus_addr  <= cpu_addr;
                bus_wdata <= '0;
              end
            end
          end
        end
        CS_REQ: begin
          if (snp_valid) begin
            if (sn_upd_en && (sn_upd_idx == cpu_idx)) begin
              bus_req <= 1'b0;
              ctl_q   <= CS_IDLE;
            end
          end else if (bus_gnt) begin
            ctl_q <= CS_WAIT;
          end
        end
        CS_WAIT: begin
          if (bus_done) begin
            bus_req <= 1'b0;
            if (cmd_q == BC_WB) begin
              ctl_q <= CS_IDLE;
            end else begin
              cpu_ready      <= 1'b1;
              cpu_rdata      <= cpu_we ? cpu_wdata : bus_rdata;
              cpu_from_cache <= bus_shared_in;
              ctl_q          <= CS_RESP;
            end
          end
        end
        default: ctl_q <= CS_IDLE;
      endcase
    end
  end

  assign bus_cmd = cmd_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bus_req && !cpu_ready && !snp_flush)); // R1
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    accept_hit |=> (cpu_ready && !bus_req)); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R4
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    wb_done |=> (!bus_req && !cpu_ready)); // R5
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == CS_WAIT && !bus_done) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R11
endmodule

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [1:0]    c0;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    logic [1:0]    c1;
    logic [DW-1:0] rd;
  } vec_t;

  // Codes: 0 none, 1 read, 2 read-for-ownership, 3 writeback.
  localparam vec_t VECS [10] = '{
    '{1'b0, 10'h011, 32'h0,         2'd1, 10'h011, 32'h0,         2'd0, 32'h10000011},
    '{1'b0, 10'h011, 32'h0,         2'd0, 10'h000, 32'h0,         2'd0, 32'h10000011},
    '{1'b1, 10'h011, 32'hAAAA0001, 2'd2, 10'h011, 32'h0,         2'd0, 32'h0},
    '{1'b0, 10'h011, 32'h0,         2'd0, 10'h000, 32'h0,         2'd0, 32'hAAAA0001},
    '{1'b1, 10'h011, 32'hAAAA0002, 2'd0, 10'h000, 32'h0,         2'd0, 32'h0},
    '{1'b0, 10'h019, 32'h0,         2'd3, 10'h011, 32'hAAAA0002, 2'd1, 32'h10000019},
    '{1'b1, 10'h022, 32'hBBBB0003, 2'd2, 10'h022, 32'h0,         2'd0, 32'h0},
    '{1'b0, 10'h011, 32'h0,         2'd1, 10'h011, 32'h0,         2'd0, 32'hAAAA0002},
    '{1'b1, 10'h02A, 32'hCCCC0004, 2'd3, 10'h022, 32'hBBBB0003, 2'd2, 32'h0},
    '{1'b0, 10'h022, 32'h0,         2'd3, 10'h02A, 32'hCCCC0004, 2'd1, 32'hBBBB0003}
  };

  logic          clk, rst;
  logic          cpu_req, cpu_we, cpu_ready, cpu_from_cache;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          bus_req, bus_gnt, bus_done, bus_shared_in;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid, snp_flush;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3)) dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_from_cache(cpu_from_cache),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [DW-1:0] mem [1 << AW];
  int            log_n;
  logic [1:0]    log_cmd  [4];
  logic [AW-1:0] log_addr [4];
  logic [DW-1:0] log_wd   [4];
  bit            gnt_hold = 1'b0;
  bit            resp_shared = 1'b0;

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h10000000 + i;
    log_n = 0;
  end

  // Bus model: grants for one cycle, completes on the next.
  initial begin
    bus_gnt = 1'b0; bus_done = 1'b0; bus_rdata = '0; bus_shared_in = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_req && !gnt_hold && !rst) begin
        logic [1:0] gcmd;
        gcmd = bus_cmd;
        if (log_n < 4) begin
          log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_wd[log_n] = bus_wdata;
        end
        log_n++;
        bus_gnt = 1'b1;
        @(negedge clk);
        chk("R11 req held", {31'd0, bus_req}, 32'd1);
        chk("R11 cmd held", {30'd0, bus_cmd}, {30'd0, gcmd});
        bus_gnt = 1'b0; bus_done = 1'b1;
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        else bus_rdata = mem[bus_addr];
        bus_shared_in = resp_shared;
        @(negedge clk);
        bus_done = 1'b0; bus_shared_in = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  logic [DW-1:0] op_rd;
  logic          op_fc;

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    op_rd = cpu_rdata; op_fc = cpu_from_cache;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       input logic ef, input logic [DW-1:0] ed, input string tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
    chk({tag, " flush"}, {31'd0, snp_flush}, {31'd0, ef});
    if (ef) begin
      chk({tag, " flush data"}, snp_data, ed);
      mem[a] = snp_data;
    end
  endtask

  task automatic chk_log(input string tag, input int n, input logic [1:0] c, input logic [AW-1:0] a);
    chk({tag, " bus count"}, n, log_n);
    if (n > 0 && log_n > 0) begin
      chk({tag, " bus cmd"}, {30'd0, log_cmd[0]}, {30'd0, c});
      chk({tag, " bus addr"}, {22'd0, log_addr[0]}, {22'd0, a});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
    do_reset();
    chk("R1 ready low", {31'd0, cpu_ready}, 32'd0);
    chk("R1 req low", {31'd0, bus_req}, 32'd0);
    chk("R1 flush low", {31'd0, snp_flush}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      vec_t  v;
      int    nexp;
      string tag;
      v = VECS[i];
      nexp = (v.c0 != 2'd0 ? 1 : 0) + (v.c1 != 2'd0 ? 1 : 0);
      case (v.c0)
        2'd1: tag = "R2";
        2'd2: tag = "R3";
        2'd3: tag = "R5";
        default: tag = "R4";
      endcase
      log_n = 0;
      cpu_op(v.we, v.addr, v.wd);
      chk({tag, " bus count"}, log_n, nexp);
      if (nexp > 0) begin
        chk({tag, " first cmd"}, {30'd0, log_cmd[0]}, {30'd0, v.c0});
        chk({tag, " first addr"}, {22'd0, log_addr[0]}, {22'd0, v.a0});
        if (v.c0 == 2'd3) chk("R5 victim data", log_wd[0], v.d0);
      end
      if (nexp > 1) begin
        chk("R5 fill after writeback", {30'd0, log_cmd[1]}, {30'd0, v.c1});
        chk("R5 fill addr", {22'd0, log_addr[1]}, {22'd0, v.addr});
      end
      if (!v.we) chk({tag, " read data"}, op_rd, v.rd);
    end

    // Snooped read on a Modified line.
    log_n = 0; cpu_op(1'b1, 10'h033, 32'hDDDD0005);
    chk_log("R3", 1, 2'd2, 10'h033);
    snoop(2'd1, 10'h033, 1'b1, 32'hDDDD0005, "R6");
    log_n = 0; cpu_op(1'b0, 10'h033, 32'h0);
    chk_log("R6 still valid", 0, 2'd0, 10'h0);
    chk("R6 data kept", op_rd, 32'hDDDD0005);
    log_n = 0; cpu_op(1'b1, 10'h033, 32'hDDDD0006);
    chk_log("R6 now shared", 1, 2'd2, 10'h033);

    // Snooped read-for-ownership on a Modified line.
    snoop(2'd2, 10'h033, 1'b1, 32'hDDDD0006, "R7");
    resp_shared = 1'b1;
    log_n = 0; cpu_op(1'b0, 10'h033, 32'h0);
    resp_shared = 1'b0;
    chk_log("R7 invalidated", 1, 2'd1, 10'h033);
    chk("R7 memory got flush", op_rd, 32'hDDDD0006);
    chk("R10 from cache set", {31'd0, op_fc}, 32'd1);

    // Snoops on a Shared line and on another tag.
    snoop(2'd2, 10'h011, 1'b0, 32'h0, "R8 rdx shared");
    log_n = 0; cpu_op(1'b0, 10'h011, 32'h0);
    chk_log("R8 shared invalidated", 1, 2'd1, 10'h011);
    chk("R10 from memory", {31'd0, op_fc}, 32'd0);
    snoop(2'd1, 10'h011, 1'b0, 32'h0, "R8 rd shared");
    log_n = 0; cpu_op(1'b0, 10'h011, 32'h0);
    chk_log("R8 shared kept", 0, 2'd0, 10'h0);
    snoop(2'd2, 10'h019, 1'b0, 32'h0, "R8 other tag");
    log_n = 0; cpu_op(1'b0, 10'h011, 32'h0);
    chk_log("R8 other tag ignored", 0, 2'd0, 10'h0);
    chk("R8 data intact", op_rd, 32'hAAAA0002);

    // Snoop steals a dirty victim while its writeback waits for grant.
    log_n = 0; cpu_op(1'b1, 10'h044, 32'hEEEE0007);
    chk_log("R3 fill m", 1, 2'd2, 10'h044);
    gnt_hold = 1'b1;
    log_n = 0;
    fork
      cpu_op(1'b1, 10'h04C, 32'hEEEE0008);
      begin
        do @(negedge clk); while (!bus_req);
        chk("R9 pending writeback", {30'd0, bus_cmd}, 32'd3);
        snoop(2'd2, 10'h044, 1'b1, 32'hEEEE0007, "R9");
        gnt_hold = 1'b0;
      end
    join
    chk_log("R9 writeback dropped", 1, 2'd2, 10'h04C);
    log_n = 0; cpu_op(1'b0, 10'h04C, 32'h0);
    chk_log("R9 line owned", 0, 2'd0, 10'h0);
    chk("R9 data", op_rd, 32'hEEEE0008);

    // Reset mid-run invalidates everything.
    do_reset();
    chk("R1 req after reset", {31'd0, bus_req}, 32'd0);
    log_n = 0; cpu_op(1'b0, 10'h04C, 32'h0);
    chk_log("R1 all invalid", 1, 2'd1, 10'h04C);
    chk("R1 data from memory", op_rd, 32'h1000004C);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule